// File: doc/BRIEF.md
# Steering Target Range Lookup

This block takes a register address and decides whether an access to it must first be steered to one replica of a replicated register, and if so which group and instance to aim at. Address windows are grouped by steering kind. Each kind has a small table of address windows that are loaded through a configuration port. Each kind also has a target group and instance that the block derives from hardware presence masks. A lookup request returns its result one clock later.

The kinds are searched in a fixed priority order, and the first kind that owns a matching window supplies the target. An extra "implicit" kind is searched only after all the others. A hit there means the access needs no steering. An address that no window covers gets steered to group 0, instance 0, and a miss flag is raised so that the caller can report the gap.

Each target is derived by taking the lowest set bit of a presence mask. The lowest enabled memory slice, the lowest enabled compute unit and the lowest enabled node each pick their kind's target. These masks are live inputs, so a lookup always uses the mask values present on the cycle it is issued.

Top module: `steer_lookup`

## Requirements
- R1: Kinds are searched in the fixed priority order cache-bank (code 0), memory-slice (1), line-cache (2), unit (3), node (4), instance-zero (5). When windows of several kinds contain the address, the lowest code supplies group and instance, with res_steer=1 and res_miss=0.
- R2: The implicit kind (code 6) is consulted only when no kind 0..5 matches. A hit there gives res_steer=0, res_miss=0, group 0 and instance 0.
- R3: An address matched by no window gives res_steer=1, res_group=0, res_inst=0 and res_miss=1.
- R4: A window matches when start <= address <= end, with both bounds included. A window whose end is zero never matches.
- R5: The unit target uses id = index of the lowest set bit of unit_mask: group = id / N and instance = id % N. N is 4 when upg_sel is 0, 6 when it is 1, and 8 when it is 2 or 3.
- R6: The memory-slice target is group = index of the lowest set bit of mslice_mask, instance 0. The line-cache target is that index shifted left by one, instance 0. An all-zero mask gives index 0.
- R7: The cache-bank target has the same group as the memory-slice target. Its instance is 0 when bank_mask bit 0 is set and 2 otherwise.
- R8: The node target takes idx = index of the lowest set bit of node_mask and gives group = idx >> 1, instance = idx & 1.
- R9: The instance-zero kind always gives group 0, instance 0, with res_steer=1 and res_miss=0.
- R10: A cycle with cfg_we=1 writes window slot cfg_slot (0..7) of kind cfg_kind with bounds cfg_start and cfg_end. A cfg_kind of 7 writes nothing. Reset empties every window.
- R11: res_valid rises exactly one cycle after lk_valid is sampled high, and the result belongs to that request. While lk_valid is low, res_valid falls on the next cycle and res_steer, res_group, res_inst and res_miss keep their values.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_kind | input | 3 | Steering kind code of the window being written |
| cfg_slot | input | 3 | Window slot within the kind |
| cfg_start | input | 24 | First address of the window |
| cfg_end | input | 24 | Last address of the window (0 = unused) |
| upg_sel | input | 2 | Units per group select (0: 4, 1: 6, 2/3: 8) |
| mslice_mask | input | 8 | Memory-slice presence mask |
| bank_mask | input | 3 | Cache-bank presence mask |
| unit_mask | input | 32 | Compute-unit presence mask |
| node_mask | input | 8 | Node presence mask |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 24 | Address to look up |
| res_valid | output | 1 | Result strobe |
| res_steer | output | 1 | Steering required |
| res_group | output | 4 | Target group |
| res_inst | output | 4 | Target instance |
| res_miss | output | 1 | No window covered the address |

## Verification
Every lookup result is due on the clock edge right after the edge that samples lk_valid. A window write takes effect at its own edge, so a lookup issued on the next cycle already sees it. The driver applies one request per cycle at the falling edge and queues the expected result, which it computes from the masks in force at that moment. The monitor compares a result on each falling edge where res_valid is high, so each queued item meets exactly the result of its own request, one cycle later. Masks change only in the same half-cycle as the request that must see them, and after each burst an idle period checks that res_valid has dropped.

// File: rtl/steer_pkg.sv
package steer_pkg;

    // Search priority follows the numeric code; IMPLICIT is always last.
    typedef enum logic [2:0] {
        ST_BANK     = 3'd0,
        ST_MSLICE   = 3'd1,
        ST_LCACHE   = 3'd2,
        ST_UNIT     = 3'd3,
        ST_NODE     = 3'd4,
        ST_INST0    = 3'd5,
        ST_IMPLICIT = 3'd6
    } steer_kind_e;

    localparam int KIND_W    = 3;
    localparam int NUM_KINDS = 7;

endpackage

// File: rtl/steer_ffs.sv
// Index of the lowest set bit; an all-zero vector yields 0.
module steer_ffs #(
    parameter  int W     = 8,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/steer_range_table.sv
module steer_range_table
    import steer_pkg::*;
#(
    parameter  int ADDR_W = 24,
    parameter  int SLOTS  = 8,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [KIND_W-1:0]    cfg_kind,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [ADDR_W-1:0]    cfg_start,
    input  logic [ADDR_W-1:0]    cfg_end,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_KINDS-1:0] hit
);

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } span_t;

    span_t tbl_d [NUM_KINDS][SLOTS];
    span_t tbl_q [NUM_KINDS][SLOTS];

    always_comb begin
        tbl_d = tbl_q;
        if (cfg_we && (int'(cfg_kind) < NUM_KINDS)) begin
            tbl_d[cfg_kind][cfg_slot] = '{lo: cfg_start, hi: cfg_end};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '{default: '0};
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // One comparator pair per window, all kinds in parallel.
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        logic [SLOTS-1:0] slot_hit;
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign slot_hit[s] = (tbl_q[k][s].hi != '0)
                              && (addr >= tbl_q[k][s].lo)
                              && (addr <= tbl_q[k][s].hi);
        end
        assign hit[k] = |slot_hit;
    end

endmodule

// File: rtl/steer_target_calc.sv
module steer_target_calc
    import steer_pkg::*;
#(
    parameter int MSLICE_W = 8,
    parameter int BANK_W   = 3,
    parameter int UNIT_W   = 32,
    parameter int NODE_W   = 8,
    parameter int GRP_W    = 4,
    parameter int INST_W   = 4
) (
    input  logic [1:0]                       upg_sel,
    input  logic [MSLICE_W-1:0]              mslice_mask,
    input  logic [BANK_W-1:0]                bank_mask,
    input  logic [UNIT_W-1:0]                unit_mask,
    input  logic [NODE_W-1:0]                node_mask,
    output logic [NUM_KINDS-1:0][GRP_W-1:0]  tgt_grp,
    output logic [NUM_KINDS-1:0][INST_W-1:0] tgt_inst
);

    localparam int MS_IDX_W   = (MSLICE_W > 1) ? $clog2(MSLICE_W) : 1;
    localparam int UNIT_IDX_W = (UNIT_W > 1) ? $clog2(UNIT_W) : 1;
    localparam int NODE_IDX_W = (NODE_W > 1) ? $clog2(NODE_W) : 1;

    logic [MS_IDX_W-1:0]   ms_idx;
    logic [UNIT_IDX_W-1:0] unit_id;
    logic [NODE_IDX_W-1:0] node_idx;

    steer_ffs #(.W(MSLICE_W)) u_ffs_ms   (.vec(mslice_mask), .idx(ms_idx));
    steer_ffs #(.W(UNIT_W))   u_ffs_unit (.vec(unit_mask),   .idx(unit_id));
    steer_ffs #(.W(NODE_W))   u_ffs_node (.vec(node_mask),   .idx(node_idx));

    int uid;

    always_comb begin
        tgt_grp  = '0;
        tgt_inst = '0;
        uid      = int'(unit_id);

        tgt_grp[ST_BANK]    = GRP_W'(ms_idx);
        tgt_inst[ST_BANK]   = bank_mask[0] ? '0 : INST_W'(2);

        tgt_grp[ST_MSLICE]  = GRP_W'(ms_idx);
        tgt_grp[ST_LCACHE]  = GRP_W'({ms_idx, 1'b0});

        // Constant divisors, muxed afterwards: no general divider.
        case (upg_sel)
            2'd0: begin
                tgt_grp[ST_UNIT]  = GRP_W'(uid / 4);
                tgt_inst[ST_UNIT] = INST_W'(uid % 4);
            end
            2'd1: begin
                tgt_grp[ST_UNIT]  = GRP_W'(uid / 6);
                tgt_inst[ST_UNIT] = INST_W'(uid % 6);
            end
            default: begin
                tgt_grp[ST_UNIT]  = GRP_W'(uid / 8);
                tgt_inst[ST_UNIT] = INST_W'(uid % 8);
            end
        endcase

        tgt_grp[ST_NODE]    = GRP_W'(node_idx >> 1);
        tgt_inst[ST_NODE]   = INST_W'(node_idx[0]);
        // ST_INST0 and ST_IMPLICIT stay at 0/0.
    end

endmodule

// File: rtl/steer_lookup.sv
module steer_lookup
    import steer_pkg::*;
#(
    parameter  int ADDR_W   = 24,
    parameter  int SLOTS    = 8,
    parameter  int MSLICE_W = 8,
    parameter  int BANK_W   = 3,
    parameter  int UNIT_W   = 32,
    parameter  int NODE_W   = 8,
    parameter  int GRP_W    = 4,
    parameter  int INST_W   = 4,
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [KIND_W-1:0]   cfg_kind,
    input  logic [SLOT_W-1:0]   cfg_slot,
    input  logic [ADDR_W-1:0]   cfg_start,
    input  logic [ADDR_W-1:0]   cfg_end,
    input  logic [1:0]          upg_sel,
    input  logic [MSLICE_W-1:0] mslice_mask,
    input  logic [BANK_W-1:0]   bank_mask,
    input  logic [UNIT_W-1:0]   unit_mask,
    input  logic [NODE_W-1:0]   node_mask,
    input  logic                lk_valid,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic                res_valid,
    output logic                res_steer,
    output logic [GRP_W-1:0]    res_group,
    output logic [INST_W-1:0]   res_inst,
    output logic                res_miss
);

    typedef struct packed {
        logic              valid;
        logic              steer;
        logic              miss;
        logic [GRP_W-1:0]  grp;
        logic [INST_W-1:0] inst;
    } res_t;

    logic [NUM_KINDS-1:0]             hit;
    logic [NUM_KINDS-1:0][GRP_W-1:0]  tgt_grp;
    logic [NUM_KINDS-1:0][INST_W-1:0] tgt_inst;
    res_t                             res_d, res_q;

    steer_range_table #(
        .ADDR_W (ADDR_W),
        .SLOTS  (SLOTS)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_slot  (cfg_slot),
        .cfg_start (cfg_start),
        .cfg_end   (cfg_end),
        .addr      (lk_addr),
        .hit       (hit)
    );

    steer_target_calc #(
        .MSLICE_W (MSLICE_W),
        .BANK_W   (BANK_W),
        .UNIT_W   (UNIT_W),
        .NODE_W   (NODE_W),
        .GRP_W    (GRP_W),
        .INST_W   (INST_W)
    ) u_targets (
        .upg_sel     (upg_sel),
        .mslice_mask (mslice_mask),
        .bank_mask   (bank_mask),
        .unit_mask   (unit_mask),
        .node_mask   (node_mask),
        .tgt_grp     (tgt_grp),
        .tgt_inst    (tgt_inst)
    );

    always_comb begin
        logic found;
        found       = 1'b0;
        res_d       = res_q;
        res_d.valid = lk_valid;
        if (lk_valid) begin
            // Default: unknown address, steer to 0/0 and flag it.
            res_d.steer = 1'b1;
            res_d.miss  = 1'b1;
            res_d.grp   = '0;
            res_d.inst  = '0;
            for (int k = 0; k < NUM_KINDS - 1; k++) begin
                if (!found && hit[k]) begin
                    found       = 1'b1;
                    res_d.miss  = 1'b0;
                    res_d.grp   = tgt_grp[k];
                    res_d.inst  = tgt_inst[k];
                end
            end
            if (!found && hit[ST_IMPLICIT]) begin
                res_d.steer = 1'b0;
                res_d.miss  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_steer = res_q.steer;
    assign res_miss  = res_q.miss;
    assign res_group = res_q.grp;
    assign res_inst  = res_q.inst;

endmodule

// File: rtl/steer_lookup_chk.sv
module steer_lookup_chk #(
    parameter int GRP_W  = 4,
    parameter int INST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              res_valid,
    input logic              res_steer,
    input logic [GRP_W-1:0]  res_group,
    input logic [INST_W-1:0] res_inst,
    input logic              res_miss
);

    // R11
    res_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R11
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && $stable(res_steer) && $stable(res_group)
                       && $stable(res_inst) && $stable(res_miss)));

    // R3
    miss_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_steer && res_group == '0 && res_inst == '0));

    // R2
    nosteer_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_steer |-> (!res_miss && res_group == '0 && res_inst == '0));

endmodule

bind steer_lookup steer_lookup_chk #(
    .GRP_W  (GRP_W),
    .INST_W (INST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .res_valid (res_valid),
    .res_steer (res_steer),
    .res_group (res_group),
    .res_inst  (res_inst),
    .res_miss  (res_miss)
);

// File: tb/steer_lookup_bench.sv
`timescale 1ns/1ps
module steer_lookup_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_kind = '0;
    logic [2:0]  cfg_slot = '0;
    logic [23:0] cfg_start = '0;
    logic [23:0] cfg_end = '0;
    logic [1:0]  upg_sel = '0;
    logic [7:0]  mslice_mask = '0;
    logic [2:0]  bank_mask = '0;
    logic [31:0] unit_mask = '0;
    logic [7:0]  node_mask = '0;
    logic        lk_valid = 1'b0;
    logic [23:0] lk_addr = '0;
    logic        res_valid;
    logic        res_steer;
    logic [3:0]  res_group;
    logic [3:0]  res_inst;
    logic        res_miss;

    always #2 clk = ~clk;

    steer_lookup u_steer_lookup (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_slot(cfg_slot), .cfg_start(cfg_start), .cfg_end(cfg_end),
        .upg_sel(upg_sel), .mslice_mask(mslice_mask), .bank_mask(bank_mask),
        .unit_mask(unit_mask), .node_mask(node_mask), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .res_valid(res_valid), .res_steer(res_steer),
        .res_group(res_group), .res_inst(res_inst), .res_miss(res_miss)
    );

    typedef struct {
        logic [23:0] addr;
        logic        steer;
        logic [3:0]  grp;
        logic [3:0]  inst;
        logic        miss;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    function automatic int lowbit(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic int per_grp();
        return (upg_sel == 2'd0) ? 4 : (upg_sel == 2'd1) ? 6 : 8;
    endfunction

    function automatic int ms_grp();
        return lowbit({24'd0, mslice_mask});
    endfunction

    function automatic int bank_inst();
        return bank_mask[0] ? 0 : 2;
    endfunction

    function automatic int unit_grp();
        return lowbit(unit_mask) / per_grp();
    endfunction

    function automatic int unit_inst();
        return lowbit(unit_mask) % per_grp();
    endfunction

    task automatic check(input bit ok, input string tag, input string msg);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    task automatic look(input logic [23:0] a, input logic s, input int g,
                        input int i, input logic m, input string tag);
        exp_t e;
        e.addr = a; e.steer = s; e.grp = 4'(g); e.inst = 4'(i);
        e.miss = m; e.tag = tag;
        sb.push_back(e);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        lk_valid = 1'b0;
        repeat (n) @(negedge clk);
        check(res_valid == 1'b0, "R11",
              $sformatf("idle res_valid got %0d exp 0", res_valid));
    endtask

    task automatic wr(input logic [2:0] k, input logic [2:0] s,
                      input logic [23:0] lo, input logic [23:0] hi);
        cfg_we = 1'b1; cfg_kind = k; cfg_slot = s;
        cfg_start = lo; cfg_end = hi;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Monitor: pops one expected item per produced result.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) begin
                if (sb.size() == 0) begin
                    n_vec++;
                    n_bad++;
                    $display("FAIL R11 unexpected result got valid=1 exp none");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(res_steer == e.steer && res_group == e.grp &&
                          res_inst == e.inst && res_miss == e.miss, e.tag,
                          $sformatf("addr=%h got s=%0d g=%0d i=%0d m=%0d exp s=%0d g=%0d i=%0d m=%0d",
                                    e.addr, res_steer, res_group, res_inst, res_miss,
                                    e.steer, e.grp, e.inst, e.miss));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R11 watchdog expired got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(res_valid == 0 && res_steer == 0 && res_group == 0 &&
              res_inst == 0 && res_miss == 0, "R12",
              $sformatf("reset outputs got v=%0d s=%0d g=%0d i=%0d m=%0d exp all 0",
                        res_valid, res_steer, res_group, res_inst, res_miss));

        mslice_mask = 8'h28;
        bank_mask   = 3'b010;
        unit_mask   = 32'h0000_0700;
        node_mask   = 8'h06;
        upg_sel     = 2'd1;

        // R10: empty table after reset, so even address 0 is a miss (R4)
        look(24'h00B100, 1, 0, 0, 1, "R10 empty after reset");
        look(24'h000000, 1, 0, 0, 1, "R4 zero end unused");
        idle(2);

        wr(3'd0, 3'd0, 24'h00B100, 24'h00B3FF);
        wr(3'd1, 3'd0, 24'h00DD00, 24'h00DDFF);
        wr(3'd1, 3'd3, 24'h00E900, 24'h00FFFF);
        wr(3'd2, 3'd0, 24'h00B000, 24'h00B0FF);
        wr(3'd2, 3'd1, 24'h00D880, 24'h00D8FF);
        wr(3'd3, 3'd0, 24'h008140, 24'h00815F);
        wr(3'd3, 3'd7, 24'h00DE80, 24'h00E8FF);
        wr(3'd4, 3'd0, 24'h000B00, 24'h000BFF);
        wr(3'd5, 3'd0, 24'h004000, 24'h004AFF);
        wr(3'd5, 3'd1, 24'h00B100, 24'h00B1FF);
        wr(3'd6, 3'd0, 24'h001000, 24'h001FFF);
        wr(3'd6, 3'd1, 24'h000B00, 24'h000BFF);
        wr(3'd7, 3'd2, 24'h002000, 24'h002FFF);

        // Back-to-back burst
        look(24'h00B100, 1, ms_grp(), bank_inst(), 0, "R1 bank beats inst0, R7");
        look(24'h00B3FF, 1, ms_grp(), bank_inst(), 0, "R4 inclusive end");
        look(24'h00B400, 1, 0, 0, 1, "R3 one past end");
        look(24'h00B0FF, 1, ms_grp() << 1, 0, 0, "R6 line-cache group");
        look(24'h00E900, 1, ms_grp(), 0, 0, "R6 memory-slice group");
        look(24'h008150, 1, unit_grp(), unit_inst(), 0, "R5 unit per 6");
        look(24'h00E8FF, 1, unit_grp(), unit_inst(), 0, "R5 slot 7 end");
        look(24'h000B80, 1, 0, 1, 0, "R8 node beats implicit, R2");
        look(24'h001800, 0, 0, 0, 0, "R2 implicit no steer");
        look(24'h004000, 1, 0, 0, 0, "R9 instance-zero kind");
        look(24'h002000, 1, 0, 0, 1, "R10 kind 7 write ignored");
        idle(3);

        bank_mask = 3'b011;
        look(24'h00B200, 1, ms_grp(), bank_inst(), 0, "R7 bank bit0 set");
        upg_sel = 2'd0;
        look(24'h008140, 1, unit_grp(), unit_inst(), 0, "R5 unit per 4");
        upg_sel = 2'd2;
        look(24'h008140, 1, unit_grp(), unit_inst(), 0, "R5 unit per 8");
        upg_sel = 2'd3;
        unit_mask = 32'h8000_0000;
        look(24'h008140, 1, unit_grp(), unit_inst(), 0, "R5 unit per 8 sel3");
        upg_sel = 2'd1;
        unit_mask = 32'h0000_0020;
        look(24'h008145, 1, unit_grp(), unit_inst(), 0, "R5 unit id 5");
        mslice_mask = 8'h00;
        look(24'h00DD00, 1, 0, 0, 0, "R6 zero mask");
        mslice_mask = 8'h80;
        look(24'h00D880, 1, 14, 0, 0, "R6 line-cache top slice");
        node_mask = 8'h80;
        look(24'h000BFF, 1, 3, 1, 0, "R8 node idx 7");
        idle(2);

        // R10 overwrite: disabling the bank window exposes instance-zero
        wr(3'd0, 3'd0, 24'h00B100, 24'h000000);
        look(24'h00B100, 1, 0, 0, 0, "R10 overwrite, R1 next kind");
        look(24'h00B300, 1, 0, 0, 1, "R3 after disable");
        idle(3);
        check(res_steer == 1 && res_miss == 1, "R11",
              $sformatf("held payload got s=%0d m=%0d exp s=1 m=1",
                        res_steer, res_miss));
        check(sb.size() == 0, "R11",
              $sformatf("pending results got %0d exp 0", sb.size()));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule